// File: doc/BRIEF.md
# Cascaded Priority Interrupt Controller

The block gathers up to sixteen external interrupt lines through two identical eight-input priority units. One unit is the master and the other is the slave. The slave's request output takes the place of the master's input 2, so fifteen lines reach the processor. A device wired to line 2 is steered onto the slave's second input, and the processor sees it as line 9. The block drives one registered interrupt output, `int_out`, which stays high until the processor acknowledges it.

On a one-cycle `inta` pulse the block picks the winning line and moves it from pending to in-service. One cycle later it returns that line's vector number, together with a one-cycle `vec_valid` strobe. While a handler is in service, only a line of higher fixed priority can raise `int_out` again. An end-of-interrupt pulse to a unit clears that unit's highest-priority in-service line. The processor can write two mask registers and a trigger-mode register through a small configuration port.

Top module: `cascaded_irq_ctrl`

## Requirements
- R1: After reset `int_out` and `vec_valid` are 0, no line is in service, both masks are clear (every line enabled) and both units are level-triggered.
- R2: An enabled line that is held high while nothing is in service raises `int_out`. `int_out` stays high, for as many cycles as needed, until `inta` is pulsed.
- R3: After each `inta` pulse, `vec_valid` is high for exactly one cycle on the next cycle, with `vec_out`. For lines 0, 1 and 3..7, `vec_out` is 0x20 + line. For lines 8..15 it is 0x28 + (line − 8).
- R4: Fixed priority, from highest to lowest, is 0, 1, 8, 9, …, 15, 3, 4, …, 7. When several lines request at once, the highest-priority one is acknowledged first.
- R5: A request on line 2 is serviced as line 9, with vector 0x29.
- R6: While a line is in service, a request of lower or equal priority leaves `int_out` low. A request of higher priority raises it.
- R7: An end-of-interrupt pulse clears the highest-priority in-service line of its unit. A slave line stays in service at the master until both `eoi_slave` and `eoi_master` have been pulsed, so until then lines 3..7 cannot interrupt.
- R8: A write with `cfg_addr` 0 sets the master mask and a write with `cfg_addr` 1 sets the slave mask, both from `cfg_data`. A 1 in bit i blocks that unit's input i. Master bit 2 blocks every slave line.
- R9: A write with `cfg_addr` 2 sets the trigger mode: bit 0 selects edge mode for the master and bit 1 for the slave. In edge mode a rising edge is latched and stays pending after the line falls. An edge that arrives while its line is masked also stays pending, and it raises `int_out` once the mask bit is cleared. Acknowledge removes the latched edge, so a line held high does not request again.
- R10: An `inta` pulse with no request pending returns vector 0x27 and changes no state.
- R11: While a slave line is in service, a higher-priority slave line raises `int_out` and is acknowledged, but a lower one does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_lines | input | 16 | External request lines 0..15 |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 2 | Configuration register select: 0 master mask, 1 slave mask, 2 trigger mode |
| cfg_data | input | 8 | Configuration write data |
| inta | input | 1 | One-cycle interrupt acknowledge |
| eoi_master | input | 1 | End-of-interrupt pulse to the master |
| eoi_slave | input | 1 | End-of-interrupt pulse to the slave |
| int_out | output | 1 | Registered interrupt request to the processor |
| vec_valid | output | 1 | One-cycle strobe that marks `vec_out` |
| vec_out | output | 8 | Vector number of the acknowledged line |

## Verification
Lines are driven one at a time, then in groups that span master and slave. The single-line cases check the vector mapping. The groups separate the priority order, in particular slave lines sitting between lines 1 and 3. Nested runs then raise lower, equal and higher lines against an in-service handler, with end-of-interrupt pulses given to one unit only, which shows whether both in-service records are kept. Mask writes, short pulses in edge mode, a held level in edge mode and an acknowledge with nothing pending cover blocking, edge latching and the case where no state may change.

// File: rtl/pic_pkg.sv
package pic_pkg;
  typedef enum logic [1:0] {
    CFG_MMASK = 2'd0,
    CFG_SMASK = 2'd1,
    CFG_MODE  = 2'd2
  } cfg_sel_e;
endpackage

// File: rtl/pic_prio_pick.sv
// Finds the lowest-index set bit, which is the highest priority.
module pic_prio_pick #(
  parameter int N  = 8,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]  vec,
  output logic          found,
  output logic [IW-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec[i]) begin
        found = 1'b1;
        idx   = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pic_route.sv
// Registers the external lines and routes them to the master and slave inputs.
module pic_route #(
  parameter int N          = 8,
  parameter int CASC_LINE  = 2,
  parameter int ALIAS_LINE = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] lines,
  output logic [N-1:0]   master_in,
  output logic [N-1:0]   slave_in
);
  localparam int ALIAS_IDX = ALIAS_LINE - N;

  logic [2*N-1:0] line_q;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= lines;
  end

  for (genvar i = 0; i < N; i++) begin : g_master
    if (i == CASC_LINE) begin : g_link
      assign master_in[i] = 1'b0;
    end else begin : g_plain
      assign master_in[i] = line_q[i];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_slave
    if (j == ALIAS_IDX) begin : g_alias
      assign slave_in[j] = line_q[N+j] | line_q[CASC_LINE];
    end else begin : g_plain
      assign slave_in[j] = line_q[N+j];
    end
  end
endmodule

// File: rtl/pic_unit.sv
// One 8-input priority unit: pending, mask and in-service state.
module pic_unit #(
  parameter int N        = 8,
  parameter int IW       = $clog2(N),
  parameter bit CASC_EN  = 1'b0,
  parameter int CASC_BIT = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [N-1:0]  lines_in,
  input  logic          casc_in,
  input  logic          edge_mode,
  input  logic          mask_we,
  input  logic [N-1:0]  mask_d,
  input  logic          ack,
  input  logic          eoi,
  output logic          int_req,
  output logic [IW-1:0] win_idx,
  output logic [N-1:0]  mask_o,
  output logic [N-1:0]  isr_o
);
  logic [N-1:0]  irr, imr, isr, line_d;
  logic [N-1:0]  raw, pend;
  logic [N-1:0]  ack_set, eoi_clr;
  logic          p_found, s_found, casc_nest;
  logic [IW-1:0] p_idx, s_idx;

  for (genvar i = 0; i < N; i++) begin : g_raw
    if (CASC_EN && i == CASC_BIT) begin : g_casc
      assign raw[i] = casc_in;
    end else begin : g_line
      assign raw[i] = edge_mode ? irr[i] : lines_in[i];
    end
  end

  assign pend = raw & ~imr;

  pic_prio_pick #(.N(N), .IW(IW)) u_pend_pick (
    .vec(pend), .found(p_found), .idx(p_idx)
  );

  pic_prio_pick #(.N(N), .IW(IW)) u_isr_pick (
    .vec(isr), .found(s_found), .idx(s_idx)
  );

  // The slave resolves its own nesting, so the link bit may request past itself.
  assign casc_nest = CASC_EN && (p_idx == IW'(CASC_BIT)) && (s_idx == IW'(CASC_BIT));

  always_comb begin
    int_req = p_found && (!s_found || (p_idx < s_idx) || casc_nest);
  end

  always_comb begin
    ack_set = '0;
    eoi_clr = '0;
    if (ack && int_req) ack_set[p_idx] = 1'b1;
    if (eoi && s_found) eoi_clr[s_idx] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irr    <= '0;
      imr    <= '0;
      isr    <= '0;
      line_d <= '0;
    end else begin
      line_d <= lines_in;
      if (mask_we) imr <= mask_d;
      if (!edge_mode) irr <= '0;
      else            irr <= (irr | (lines_in & ~line_d)) & ~ack_set;
      isr <= (isr & ~eoi_clr) | ack_set;
    end
  end

  assign win_idx = p_idx;
  assign mask_o  = imr;
  assign isr_o   = isr;
endmodule

// File: rtl/cascaded_irq_ctrl.sv
module cascaded_irq_ctrl #(
  parameter int             N           = 8,
  parameter int             VW          = 8,
  parameter logic [VW-1:0]  MASTER_BASE = 8'h20,
  parameter logic [VW-1:0]  SLAVE_BASE  = 8'h28,
  parameter int             CASC_LINE   = 2,
  parameter int             ALIAS_LINE  = 9
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [2*N-1:0] irq_lines,
  input  logic           cfg_we,
  input  logic [1:0]     cfg_addr,
  input  logic [N-1:0]   cfg_data,
  input  logic           inta,
  input  logic           eoi_master,
  input  logic           eoi_slave,
  output logic           int_out,
  output logic           vec_valid,
  output logic [VW-1:0]  vec_out
);
  import pic_pkg::*;

  localparam int IW = $clog2(N);

  logic [N-1:0]  master_in, slave_in;
  logic [1:0]    mode_q;
  logic          m_int, s_int, s_ack, m_is_casc;
  logic [IW-1:0] m_win, s_win;
  logic [N-1:0]  m_mask, s_mask, m_isr, s_isr;
  logic [VW-1:0] vec_next;

  pic_route #(.N(N), .CASC_LINE(CASC_LINE), .ALIAS_LINE(ALIAS_LINE)) u_route (
    .clk(clk), .rst(rst), .lines(irq_lines),
    .master_in(master_in), .slave_in(slave_in)
  );

  always_ff @(posedge clk) begin
    if (rst) mode_q <= 2'b00;
    else if (cfg_we && cfg_addr == CFG_MODE) mode_q <= cfg_data[1:0];
  end

  assign m_is_casc = (m_win == IW'(CASC_LINE));
  assign s_ack     = inta && m_int && m_is_casc;

  pic_unit #(.N(N), .IW(IW), .CASC_EN(1'b1), .CASC_BIT(CASC_LINE)) u_master (
    .clk(clk), .rst(rst), .lines_in(master_in), .casc_in(s_int),
    .edge_mode(mode_q[0]),
    .mask_we(cfg_we && cfg_addr == CFG_MMASK), .mask_d(cfg_data),
    .ack(inta), .eoi(eoi_master),
    .int_req(m_int), .win_idx(m_win), .mask_o(m_mask), .isr_o(m_isr)
  );

  pic_unit #(.N(N), .IW(IW), .CASC_EN(1'b0), .CASC_BIT(CASC_LINE)) u_slave (
    .clk(clk), .rst(rst), .lines_in(slave_in), .casc_in(1'b0),
    .edge_mode(mode_q[1]),
    .mask_we(cfg_we && cfg_addr == CFG_SMASK), .mask_d(cfg_data),
    .ack(s_ack), .eoi(eoi_slave),
    .int_req(s_int), .win_idx(s_win), .mask_o(s_mask), .isr_o(s_isr)
  );

  always_comb begin
    if (!m_int)         vec_next = MASTER_BASE + VW'(N - 1);
    else if (m_is_casc) vec_next = SLAVE_BASE + VW'(s_win);
    else                vec_next = MASTER_BASE + VW'(m_win);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      int_out   <= 1'b0;
      vec_valid <= 1'b0;
      vec_out   <= '0;
    end else begin
      int_out   <= m_int;
      vec_valid <= inta;
      if (inta) vec_out <= vec_next;
    end
  end
endmodule

// File: rtl/pic_cascade_chk.sv
module pic_cascade_chk #(
  parameter int             N           = 8,
  parameter int             VW          = 8,
  parameter logic [VW-1:0]  MASTER_BASE = 8'h20,
  parameter logic [VW-1:0]  SLAVE_BASE  = 8'h28,
  parameter int             CASC_LINE   = 2,
  parameter int             IW          = $clog2(N)
) (
  input logic          clk,
  input logic          rst,
  input logic          inta,
  input logic          vec_valid,
  input logic [VW-1:0] vec_out,
  input logic          m_int,
  input logic [IW-1:0] m_win,
  input logic [N-1:0]  m_mask,
  input logic [N-1:0]  m_isr,
  input logic [N-1:0]  s_isr
);
  assert_ack_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    inta |=> vec_valid);

  assert_vec_range_R3: assert property (@(posedge clk) disable iff (rst)
    vec_valid |-> (vec_out[VW-1:IW] == MASTER_BASE[VW-1:IW] ||
                   vec_out[VW-1:IW] == SLAVE_BASE[VW-1:IW]));

  assert_mask_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    (inta && m_int) |-> !m_mask[m_win]);

  assert_casc_inservice_R7: assert property (@(posedge clk) disable iff (rst)
    (inta && m_int && m_win == IW'(CASC_LINE)) |=> (m_isr[CASC_LINE] && s_isr != '0));

  assert_isr_step_R6: assert property (@(posedge clk) disable iff (rst)
    inta |=> ($countones(m_isr) <= $countones($past(m_isr)) + 1));
endmodule

bind cascaded_irq_ctrl pic_cascade_chk #(
  .N(N), .VW(VW), .MASTER_BASE(MASTER_BASE), .SLAVE_BASE(SLAVE_BASE),
  .CASC_LINE(CASC_LINE)
) u_chk (
  .clk(clk), .rst(rst), .inta(inta), .vec_valid(vec_valid), .vec_out(vec_out),
  .m_int(m_int), .m_win(m_win), .m_mask(m_mask), .m_isr(m_isr), .s_isr(s_isr)
);

// File: tb/sim_cascaded_irq_ctrl.sv
module sim_cascaded_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] irq_lines = '0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_addr = '0;
  logic [7:0]  cfg_data = '0;
  logic        inta = 1'b0, eoi_master = 1'b0, eoi_slave = 1'b0;
  logic        int_out, vec_valid;
  logic [7:0]  vec_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] expq[$];
  string      tagq[$];

  always #5 clk = ~clk;

  cascaded_irq_ctrl u0 (
    .clk(clk), .rst(rst), .irq_lines(irq_lines), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_data(cfg_data), .inta(inta),
    .eoi_master(eoi_master), .eoi_slave(eoi_slave),
    .int_out(int_out), .vec_valid(vec_valid), .vec_out(vec_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_bit(input string tag, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic ack(input logic [7:0] exp, input string tag);
    expq.push_back(exp);
    tagq.push_back(tag);
    inta = 1'b1;
    tick(1);
    inta = 1'b0;
    tick(1);
  endtask

  task automatic eoi_m();
    eoi_master = 1'b1; tick(1); eoi_master = 1'b0; tick(1);
  endtask

  task automatic eoi_s();
    eoi_slave = 1'b1; tick(1); eoi_slave = 1'b0; tick(1);
  endtask

  task automatic cfg(input logic [1:0] a, input logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_data = d; tick(1); cfg_we = 1'b0; tick(1);
  endtask

  task automatic pulse(input int line);
    irq_lines[line] = 1'b1; tick(2); irq_lines[line] = 1'b0;
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && vec_valid) begin
      total++;
      if (expq.size() == 0) begin
        bad++;
        $display("FAIL R3 unexpected vector actual=%h expected=none", vec_out);
      end else begin
        logic [7:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        if (vec_out !== e) begin
          bad++;
          $display("FAIL %s vector actual=%h expected=%h", t, vec_out, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst = 1'b0;
    tick(1);
    check_bit("R1 int_out after reset", int_out, 1'b0);
    check_bit("R1 vec_valid after reset", vec_valid, 1'b0);

    // R2 / R6 level requests and nesting
    irq_lines[5] = 1'b1; tick(3);
    check_bit("R2 line5 raises int", int_out, 1'b1);
    tick(6);
    check_bit("R2 int held until ack", int_out, 1'b1);
    ack(8'h25, "R3 line5");
    tick(2);
    check_bit("R6 equal priority blocked", int_out, 1'b0);
    irq_lines[7] = 1'b1; tick(3);
    check_bit("R6 lower priority blocked", int_out, 1'b0);
    irq_lines[3] = 1'b1; tick(3);
    check_bit("R6 higher priority preempts", int_out, 1'b1);
    ack(8'h23, "R6 line3");
    irq_lines[3] = 1'b0; irq_lines[5] = 1'b0; irq_lines[7] = 1'b0;
    eoi_m(); eoi_m(); tick(2);
    check_bit("R7 all eoi leaves int low", int_out, 1'b0);

    // R4 priority order
    irq_lines[1] = 1'b1; irq_lines[4] = 1'b1; irq_lines[10] = 1'b1; tick(3);
    ack(8'h21, "R4 line1 first");
    irq_lines[1] = 1'b0; eoi_m(); tick(2);
    ack(8'h2A, "R4 line10 before line4");
    irq_lines[10] = 1'b0; eoi_s(); eoi_m(); tick(2);
    ack(8'h24, "R4 line4 last");
    irq_lines[4] = 1'b0; eoi_m(); tick(2);
    check_bit("R4 idle after group", int_out, 1'b0);

    // R5 line 2 rerouted
    irq_lines[2] = 1'b1; tick(3);
    check_bit("R5 line2 raises int", int_out, 1'b1);
    ack(8'h29, "R5 line2 as line9");
    irq_lines[2] = 1'b0; eoi_s(); eoi_m(); tick(2);

    // R7 both eoi needed for slave line
    irq_lines[12] = 1'b1; tick(3);
    ack(8'h2C, "R7 line12");
    irq_lines[12] = 1'b0;
    irq_lines[5] = 1'b1; tick(3);
    check_bit("R7 line5 blocked by slave handler", int_out, 1'b0);
    eoi_s(); tick(2);
    check_bit("R7 slave eoi alone not enough", int_out, 1'b0);
    eoi_m(); tick(2);
    check_bit("R7 master eoi releases line5", int_out, 1'b1);
    ack(8'h25, "R7 line5");
    irq_lines[5] = 1'b0; eoi_m(); tick(2);

    // R11 slave nesting
    irq_lines[13] = 1'b1; tick(3);
    ack(8'h2D, "R11 line13");
    irq_lines[13] = 1'b0;
    irq_lines[15] = 1'b1; tick(3);
    check_bit("R11 lower slave blocked", int_out, 1'b0);
    irq_lines[9] = 1'b1; tick(3);
    check_bit("R11 higher slave preempts", int_out, 1'b1);
    ack(8'h29, "R11 line9");
    irq_lines[9] = 1'b0; irq_lines[15] = 1'b0;
    eoi_s(); eoi_s(); eoi_m(); tick(2);
    check_bit("R11 idle after nesting", int_out, 1'b0);

    // R8 masking
    cfg(2'd0, 8'h08);
    irq_lines[3] = 1'b1; tick(3);
    check_bit("R8 masked line3 blocked", int_out, 1'b0);
    irq_lines[6] = 1'b1; tick(3);
    check_bit("R8 unmasked line6 passes", int_out, 1'b1);
    ack(8'h26, "R8 line6 past masked line3");
    irq_lines[6] = 1'b0; irq_lines[3] = 1'b0; eoi_m();
    cfg(2'd0, 8'h04);
    irq_lines[8] = 1'b1; tick(3);
    check_bit("R8 link mask blocks slave", int_out, 1'b0);
    cfg(2'd1, 8'h01); cfg(2'd0, 8'h00); tick(2);
    check_bit("R8 slave mask blocks line8", int_out, 1'b0);
    cfg(2'd1, 8'h00); tick(2);
    check_bit("R8 unmask line8", int_out, 1'b1);
    ack(8'h28, "R8 line8");
    irq_lines[8] = 1'b0; eoi_s(); eoi_m(); tick(2);

    // R9 edge mode
    cfg(2'd2, 8'h03); tick(2);
    pulse(4); tick(4);
    check_bit("R9 edge latched after line fell", int_out, 1'b1);
    ack(8'h24, "R9 edge line4");
    tick(2);
    eoi_m(); tick(2);
    check_bit("R9 edge cleared by ack", int_out, 1'b0);
    cfg(2'd0, 8'h80);
    pulse(7); tick(4);
    check_bit("R9 masked edge no int", int_out, 1'b0);
    cfg(2'd0, 8'h00); tick(2);
    check_bit("R9 masked edge kept pending", int_out, 1'b1);
    ack(8'h27, "R9 line7 after unmask");
    eoi_m();
    irq_lines[6] = 1'b1; tick(4);
    ack(8'h26, "R9 held line6");
    eoi_m(); tick(3);
    check_bit("R9 held level no re-request", int_out, 1'b0);
    irq_lines[6] = 1'b0;
    pulse(11); tick(4);
    ack(8'h2B, "R9 slave edge line11");
    eoi_s(); eoi_m(); tick(2);

    // R10 spurious acknowledge
    check_bit("R10 idle before spurious", int_out, 1'b0);
    ack(8'h27, "R10 spurious vector");
    tick(2);
    check_bit("R10 no int after spurious", int_out, 1'b0);
    pulse(5); tick(4);
    ack(8'h25, "R10 state intact after spurious");
    eoi_m(); tick(3);

    total++;
    if (expq.size() != 0) begin
      bad++;
      $display("FAIL R3 missing vectors actual=%0d expected=0", expq.size());
    end
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule